// File: doc/BRIEF.md
# GPIO Interrupt Line Router

This block sits between three GPIO instances and the platform interrupt controller. The instances have 14, 24 and 32 ports. It folds their per-port interrupt lines onto 41 controller inputs. The first 32 controller inputs are shared. A 32-bit select register decides, one bit per line, whether line n carries a port of the largest instance (C) or the default port from the two smaller instances (A on lines 0..13, B ports 0..17 on lines 14..31). Lines 32..37 always carry B ports 18..23.

A port that has lost its direct line is not dropped. It is ORed into an aggregate line for its own instance: line 38 for A, 39 for B and 40 for C. Each aggregate line has a software enable. Software loads the select register and sets or clears the enables through a small synchronous write port. All 41 outputs are registered.

Top module: `gpio_irq_router`

## Requirements
- R1: While reset is asserted all 41 outputs are low. Reset leaves the select register at zero and all three aggregate enables clear, so after reset no C port reaches lines 0..31 and lines 38..40 stay low.
- R2: For n in 0..13, when select bit n is 0, line n carries A port n.
- R3: For n in 14..31, when select bit n is 0, line n carries B port n-14.
- R4: For n in 0..31, when select bit n is 1, line n carries C port n, and the A or B port that would otherwise use that line has no effect on it.
- R5: Lines 32..37 carry B ports 18..23 whatever the select and enable values are.
- R6: Line 38 is aggregate enable bit 0 ANDed with the OR of every A port n whose select bit n is 1.
- R7: Line 39 is aggregate enable bit 1 ANDed with the OR of every B port j (0..17) whose select bit j+14 is 1. B ports 18..23 never contribute.
- R8: Line 40 is aggregate enable bit 2 ANDed with the OR of every C port n whose select bit n is 0.
- R9: Every output is registered. A change on an interrupt input appears on the outputs at the first rising clock edge after it, and not before.
- R10: A write to address 0 loads all 32 bits of write data into the select register at the clock edge. The outputs reflect the new select value one edge later.
- R11: A write to address 1 sets each aggregate enable whose bit in write data bits 2..0 is 1. A write to address 2 clears each enable whose bit is 1. Enable bits written as 0 keep their value.
- R12: A write to address 3 changes neither the select register nor the enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 select, 1 enable set, 2 enable clear, 3 reserved |
| wr_data | input | 32 | Write data |
| irq_a_i | input | 14 | Interrupt lines of instance A |
| irq_b_i | input | 24 | Interrupt lines of instance B |
| irq_c_i | input | 32 | Interrupt lines of instance C |
| irq_o | output | 41 | Interrupt-controller inputs, registered |

## Verification
On every cycle, the assertions check the per-line choice between default ports and C ports, the fixed B lines, and the gating of each aggregate line by its enable. They also check how each write address affects the select and enable registers. Whether an aggregate line holds exactly the right set of ports across many select patterns can only be shown by the bench sweeps. These walk single ports and mixed patterns of every instance across walking and dense select values. The same applies to the exact edge at which an output moves and to a reserved write leaving the routing untouched.

// File: rtl/gpio_irq_route_pkg.sv
package gpio_irq_route_pkg;

  typedef enum logic [1:0] {
    CFG_SEL    = 2'd0,
    CFG_EN_SET = 2'd1,
    CFG_EN_CLR = 2'd2,
    CFG_RSVD   = 2'd3
  } cfg_addr_e;

  localparam int AGG_W = 3;

endpackage

// File: rtl/gpio_irq_cfg_regs.sv
module gpio_irq_cfg_regs
  import gpio_irq_route_pkg::*;
#(
  parameter int SEL_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [SEL_W-1:0] wr_data,
  output logic [SEL_W-1:0] sel_q,
  output logic [AGG_W-1:0] agg_en_q
);

  cfg_addr_e        addr;
  logic             sel_load;
  logic             en_load;
  logic [SEL_W-1:0] sel_d;
  logic [AGG_W-1:0] en_d;

  assign addr = cfg_addr_e'(wr_addr);

  always_comb begin
    sel_load = 1'b0;
    en_load  = 1'b0;
    sel_d    = sel_q;
    en_d     = agg_en_q;
    if (wr_en) begin
      unique case (addr)
        CFG_SEL: begin
          sel_load = 1'b1;
          sel_d    = wr_data;
        end
        CFG_EN_SET: begin
          en_load = 1'b1;
          en_d    = agg_en_q | wr_data[AGG_W-1:0];
        end
        CFG_EN_CLR: begin
          en_load = 1'b1;
          en_d    = agg_en_q & ~wr_data[AGG_W-1:0];
        end
        default: begin
          sel_load = 1'b0;
          en_load  = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_load) begin
      sel_q <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      agg_en_q <= '0;
    end else if (en_load) begin
      agg_en_q <= en_d;
    end
  end

  // R10
  sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0) |=> (sel_q == $past(wr_data)));

  // R11
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1) |=> ((agg_en_q & $past(wr_data[AGG_W-1:0])) == $past(wr_data[AGG_W-1:0])));

  // R11
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2) |=> ((agg_en_q & $past(wr_data[AGG_W-1:0])) == '0));

  // R11
  en_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == 2'd1 || wr_addr == 2'd2))
      |=> ((agg_en_q & ~$past(wr_data[AGG_W-1:0])) == ($past(agg_en_q) & ~$past(wr_data[AGG_W-1:0]))));

  // R12
  rsvd_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd3) |=> ($stable(sel_q) && $stable(agg_en_q)));

  // R10
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == 2'd0) |=> $stable(sel_q));

endmodule

// File: rtl/gpio_irq_lane_mux.sv
module gpio_irq_lane_mux #(
  parameter int N_A = 14,
  parameter int N_B = 24,
  parameter int N_C = 32,
  localparam int SHARED_B = N_C - N_A,
  localparam int FIXED_B  = N_B - SHARED_B,
  localparam int DIRECT_W = N_C + FIXED_B
) (
  input  logic [N_C-1:0]      sel,
  input  logic [N_A-1:0]      irq_a,
  input  logic [N_B-1:0]      irq_b,
  input  logic [N_C-1:0]      irq_c,
  output logic [DIRECT_W-1:0] direct
);

  for (genvar n = 0; n < N_A; n++) begin : g_lane_a
    assign direct[n] = sel[n] ? irq_c[n] : irq_a[n];
  end

  for (genvar n = N_A; n < N_C; n++) begin : g_lane_b
    assign direct[n] = sel[n] ? irq_c[n] : irq_b[n-N_A];
  end

  for (genvar m = 0; m < FIXED_B; m++) begin : g_lane_fixed
    assign direct[N_C+m] = irq_b[SHARED_B+m];
  end

endmodule

// File: rtl/gpio_irq_leftover.sv
module gpio_irq_leftover
  import gpio_irq_route_pkg::*;
#(
  parameter int N_A = 14,
  parameter int N_C = 32,
  localparam int SHARED_B = N_C - N_A
) (
  input  logic [N_C-1:0]      sel,
  input  logic [AGG_W-1:0]    agg_en,
  input  logic [N_A-1:0]      irq_a,
  input  logic [SHARED_B-1:0] irq_b_shared,
  input  logic [N_C-1:0]      irq_c,
  output logic [AGG_W-1:0]    agg
);

  logic [N_A-1:0]      left_a;
  logic [SHARED_B-1:0] left_b;
  logic [N_C-1:0]      left_c;

  always_comb begin
    left_a = irq_a & sel[N_A-1:0];
    left_b = irq_b_shared & sel[N_C-1:N_A];
    left_c = irq_c & ~sel;
    agg[0] = agg_en[0] & (|left_a);
    agg[1] = agg_en[1] & (|left_b);
    agg[2] = agg_en[2] & (|left_c);
  end

endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gpio_irq_route_pkg::*;
#(
  parameter int N_A = 14,
  parameter int N_B = 24,
  parameter int N_C = 32,
  localparam int SHARED_B = N_C - N_A,
  localparam int FIXED_B  = N_B - SHARED_B,
  localparam int DIRECT_W = N_C + FIXED_B,
  localparam int OUT_W    = DIRECT_W + AGG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [N_C-1:0]   wr_data,
  input  logic [N_A-1:0]   irq_a_i,
  input  logic [N_B-1:0]   irq_b_i,
  input  logic [N_C-1:0]   irq_c_i,
  output logic [OUT_W-1:0] irq_o
);

  logic [N_C-1:0]      sel_q;
  logic [AGG_W-1:0]    agg_en_q;
  logic [DIRECT_W-1:0] direct;
  logic [AGG_W-1:0]    agg;
  logic [OUT_W-1:0]    irq_d;

  gpio_irq_cfg_regs #(.SEL_W(N_C)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sel_q    (sel_q),
    .agg_en_q (agg_en_q)
  );

  gpio_irq_lane_mux #(.N_A(N_A), .N_B(N_B), .N_C(N_C)) u_lanes (
    .sel    (sel_q),
    .irq_a  (irq_a_i),
    .irq_b  (irq_b_i),
    .irq_c  (irq_c_i),
    .direct (direct)
  );

  gpio_irq_leftover #(.N_A(N_A), .N_C(N_C)) u_left (
    .sel          (sel_q),
    .agg_en       (agg_en_q),
    .irq_a        (irq_a_i),
    .irq_b_shared (irq_b_i[SHARED_B-1:0]),
    .irq_c        (irq_c_i),
    .agg          (agg)
  );

  always_comb begin
    irq_d = {agg, direct};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o <= '0;
    end else begin
      irq_o <= irq_d;
    end
  end

  for (genvar n = 0; n < N_A; n++) begin : g_chk_a
    // R2
    lane_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_q[n] |=> (irq_o[n] == $past(irq_a_i[n])));
  end

  for (genvar n = N_A; n < N_C; n++) begin : g_chk_b
    // R3
    lane_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_q[n] |=> (irq_o[n] == $past(irq_b_i[n-N_A])));
  end

  for (genvar n = 0; n < N_C; n++) begin : g_chk_c
    // R4
    lane_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_q[n] |=> (irq_o[n] == $past(irq_c_i[n])));
  end

  for (genvar m = 0; m < FIXED_B; m++) begin : g_chk_fixed
    // R5
    lane_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_b_i[SHARED_B+m] |=> irq_o[N_C+m]);
  end

  for (genvar k = 0; k < AGG_W; k++) begin : g_chk_gate
    // R6 R7 R8
    agg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !agg_en_q[k] |=> !irq_o[DIRECT_W+k]);
  end

  // R8
  agg_c_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (agg_en_q[2] && |(irq_c_i & ~sel_q)) |=> irq_o[DIRECT_W+2]);

  // R6
  agg_a_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_a_i & sel_q[N_A-1:0]) == '0) |=> !irq_o[DIRECT_W]);

endmodule

// File: tb/sim_gpio_irq_router.sv
`timescale 1ns/1ps
module sim_gpio_irq_router;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic [13:0] irq_a;
  logic [23:0] irq_b;
  logic [31:0] irq_c;
  logic [40:0] irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] sel_m;
  logic [2:0]  en_m;
  logic [40:0] prev_exp;
  logic [31:0] lfsr;

  always #2 clk = ~clk;

  gpio_irq_router u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_a_i(irq_a), .irq_b_i(irq_b), .irq_c_i(irq_c), .irq_o(irq_o)
  );

  function automatic logic [40:0] model(logic [31:0] s, logic [2:0] e,
                                        logic [13:0] a, logic [23:0] b, logic [31:0] c);
    logic [40:0] r;
    logic o_a, o_b, o_c;
    r = '0; o_a = 1'b0; o_b = 1'b0; o_c = 1'b0;
    for (int n = 0; n < 14; n++) begin
      r[n] = s[n] ? c[n] : a[n];
      o_a  = o_a | (a[n] & s[n]);
    end
    for (int n = 14; n < 32; n++) begin
      r[n] = s[n] ? c[n] : b[n-14];
      o_b  = o_b | (b[n-14] & s[n]);
    end
    for (int n = 32; n < 38; n++) r[n] = b[n-14];
    for (int n = 0; n < 32; n++) o_c = o_c | (c[n] & ~s[n]);
    r[38] = e[0] & o_a;
    r[39] = e[1] & o_b;
    r[40] = e[2] & o_c;
    return r;
  endfunction

  task automatic check_one(string tag, logic [40:0] act, logic [40:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_vec(logic [40:0] exp);
    logic [40:0] m;
    m = 41'h0 | 41'h3FFF;               check_one("R2 R4 lanes 0..13",  irq_o & m, exp & m);
    m = 41'h0 | (41'h3FFFF << 14);      check_one("R3 R4 lanes 14..31", irq_o & m, exp & m);
    m = 41'h0 | (41'h3F << 32);         check_one("R5 lanes 32..37",    irq_o & m, exp & m);
    m = 41'h1 << 38;                    check_one("R6 line 38",         irq_o & m, exp & m);
    m = 41'h1 << 39;                    check_one("R7 line 39",         irq_o & m, exp & m);
    m = 41'h1 << 40;                    check_one("R8 line 40",         irq_o & m, exp & m);
  endtask

  task automatic drive(logic [13:0] a, logic [23:0] b, logic [31:0] c);
    @(negedge clk);
    irq_a = a; irq_b = b; irq_c = c;
    #1;
    check_one("R9 no early change", irq_o, prev_exp);
    @(negedge clk);
    prev_exp = model(sel_m, en_m, a, b, c);
    check_vec(prev_exp);
  endtask

  task automatic cfg_write(logic [1:0] addr, logic [31:0] data, string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = addr; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
    case (addr)
      2'd0: sel_m = data;
      2'd1: en_m = en_m | data[2:0];
      2'd2: en_m = en_m & ~data[2:0];
      default: ;
    endcase
    @(negedge clk);
    prev_exp = model(sel_m, en_m, irq_a, irq_b, irq_c);
    check_one(tag, irq_o, prev_exp);
  endtask

  function automatic logic [31:0] step(logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    irq_a = '1; irq_b = '1; irq_c = '1;
    sel_m = '0; en_m = '0; lfsr = 32'h1234_5678;
    repeat (3) @(negedge clk);
    check_one("R1 outputs low in reset", irq_o, '0);
    rst_n = 1'b1;
    @(negedge clk);
    prev_exp = model(32'h0, 3'b000, '1, '1, '1);
    check_one("R1 reset select and enables", irq_o, prev_exp);

    // R11 and R12 enable handling
    cfg_write(2'd0, 32'hFFFF_FFFF, "R10 load select");
    cfg_write(2'd1, 32'hFFFF_FFFA, "R11 set bit 1 only");
    cfg_write(2'd1, 32'h0000_0004, "R11 set bit 2 keeps bit 1");
    cfg_write(2'd2, 32'hFFFF_FFFA, "R11 clear bit 1 keeps bit 2");
    cfg_write(2'd3, 32'h0000_0000, "R12 reserved write ignored");
    drive(14'h0001, 24'h0, 32'h0);
    cfg_write(2'd1, 32'h0000_0007, "R11 set all");
    cfg_write(2'd3, 32'hFFFF_FFFF, "R12 reserved write ignored again");
    drive(14'h0001, 24'h000001, 32'h0);

    for (int i = 0; i < 36; i++) begin
      logic [31:0] s;
      if (i < 32)       s = 32'h1 << i;
      else if (i == 32) s = 32'h0;
      else if (i == 33) s = 32'hFFFF_FFFF;
      else if (i == 34) s = 32'hAAAA_AAAA;
      else              s = 32'h5555_5555;
      cfg_write(2'd0, s, "R10 select sweep");
      cfg_write(2'd2, 32'h7, "R11 clear sweep");
      cfg_write(2'd1, 32'(i % 8), "R11 set sweep");
      drive('0, '0, '0);
      for (int k = 0; k < 14; k++) drive(14'h1 << k, '0, '0);
      for (int k = 0; k < 24; k++) drive('0, 24'h1 << k, '0);
      for (int k = 0; k < 32; k++) drive('0, '0, 32'h1 << k);
      for (int k = 0; k < 6; k++) begin
        logic [31:0] r1, r2, r3;
        r1 = step(lfsr); r2 = step(r1); r3 = step(r2); lfsr = r3;
        drive(r1[13:0], r2[23:0], r3);
      end
      drive('1, '1, '1);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule